// File: doc/BRIEF.md
# Real-Time-Clock Interrupt Emulator

This block produces three clock-style interrupt sources from one fixed-rate base tick. The tick comes from a comparator channel of a free-running counter. The first source is an update event that fires once each time the seconds value changes. The second is an alarm that fires when the current hour, minute and second equal programmed values. The third is a periodic event at a power-of-two rate. When the periodic rate is at or below the base rate of 2^BASE_LOG2 ticks per second, the block divides the base tick down. When the rate is above the base rate, the block shortens the comparator interval instead.

After every tick the block advances its comparator target by one interval. It keeps advancing the target until it lies ahead of the live counter. The comparison uses the sign of the wrapped difference, so it stays correct across wraparound. Each advance beyond the first is a lost tick, and lost ticks are added to the periodic divide count. On a tick that raises any source, the block emits a 16-bit flag word with a one-clock strobe.

A three-state machine sequences each tick:
- IDLE waits for a tick. An accepted tick samples the sources, makes the first advance, and takes the transition IDLE->CHASE.
- CHASE repeats the advance while the target is not ahead of the counter. Once the target is ahead, it takes CHASE->EMIT if any flag was raised, or CHASE->IDLE if none was.
- EMIT asserts the strobe for one clock and returns via EMIT->IDLE.

Top module: `rtc_tick_emu`

## Requirements
- R1: After reset the outputs read as follows: `tick_en` is 0, `irq_strobe` is 0, `irq_word` is 0 and `cmp_target` is 0. The rate code resets to BASE_LOG2.
- R2: A write to the mask register (`wr_addr`=0, mask in `wr_data[2:0]`) that makes the mask non-zero while it was all zero sets `tick_en` to 1. The same write loads `cmp_target` with the sampled `counter` plus the current interval.
- R3: A mask write of all zero clears `tick_en`. While `tick_en` is 0, a tick changes neither `cmp_target` nor the outputs.
- R4: With periodic enabled (mask bit 0) and rate code k ≤ BASE_LOG2 (`wr_addr`=2, `wr_data[3:0]` holds log2 of the rate), the periodic flag is raised on every 2^(BASE_LOG2-k)-th tick counted from enabling. In this case the interval is BASE_INTERVAL.
- R5: With rate code k > BASE_LOG2, every tick raises the periodic flag, and the interval becomes BASE_INTERVAL >> (k-BASE_LOG2), with a minimum of 1.
- R6: With alarm enabled (mask bit 1), a tick raises the alarm flag exactly when all three time inputs equal the alarm register. The alarm register is written at `wr_addr`=1, with hour in `wr_data[23:16]`, minute in `[15:8]` and second in `[7:0]`.
- R7: With update enabled (mask bit 2), a tick raises the update flag when `cur_sec` differs from the last recorded seconds value. Turning mask bit 2 on marks the record invalid, so the first tick afterwards only records the seconds value and raises no flag.
- R8: A flagged tick yields `irq_strobe` high for exactly one clock, with `irq_word` laid out as follows: [15:8]=0x01, [7]=1, [6:3]=0, [2]=update, [1]=alarm, [0]=periodic. `irq_word` holds its value until the next strobe, and a tick with no flag produces no strobe.
- R9: After a tick, `cmp_target` is advanced by the interval until it is strictly ahead of `counter`. Each advance beyond the first counts as one lost tick.
- R10: Each lost tick adds one to the periodic divide count when periodic is enabled. The count saturates at the divide limit.
- R11: The ahead test is the sign of the 32-bit difference `cmp_target - counter`, so a target that has wrapped past zero counts as ahead of a counter just below 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Comparator match pulse from the timer channel |
| counter | input | 32 | Live value of the free-running counter |
| cur_hour | input | 8 | Current hour |
| cur_min | input | 8 | Current minute |
| cur_sec | input | 8 | Current second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 mask, 1 alarm, 2 rate |
| wr_data | input | 24 | Register write data |
| tick_en | output | 1 | Tick channel enabled |
| cmp_target | output | 32 | Comparator target for the next tick |
| irq_strobe | output | 1 | One-clock flag word valid |
| irq_word | output | 16 | Packed interrupt flag word |

## Verification
The bench builds the block with BASE_LOG2=6 and BASE_INTERVAL=32. With these values each comparator interval is only 32 counts, so a long divide such as one periodic event per eight ticks completes in a few hundred clocks. The same values let rate codes 7 and 8 show a halved and a quartered interval. Because the bench drives `counter` itself, it can jump the counter three intervals past the target, which makes the lost-tick chase run. It can also place the target just below 2^32 to exercise the signed wraparound test.

// File: rtl/rtc_tick_emu_pkg.sv
package rtc_tick_emu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHASE = 2'd1,
        ST_EMIT  = 2'd2
    } rte_state_t;

    localparam logic [1:0] REG_MASK  = 2'd0;
    localparam logic [1:0] REG_ALARM = 2'd1;
    localparam logic [1:0] REG_RATE  = 2'd2;

    localparam int SRC_PER = 0;
    localparam int SRC_ALM = 1;
    localparam int SRC_UPD = 2;
    localparam int NUM_SRC = 3;

    localparam logic [7:0] WORD_TAG = 8'h01;

endpackage

// File: rtl/rte_rate_decode.sv
module rte_rate_decode #(
    parameter int CNT_W         = 32,
    parameter int RATE_W        = 4,
    parameter int BASE_LOG2     = 6,
    parameter int BASE_INTERVAL = 1024,
    parameter int DIV_W         = BASE_LOG2 + 2
) (
    input  logic [RATE_W-1:0] rate,
    output logic [DIV_W-1:0]  div_limit,
    output logic [CNT_W-1:0]  interval
);
    localparam logic [RATE_W-1:0] BASE_CODE = RATE_W'(BASE_LOG2);
    localparam logic [CNT_W-1:0]  BASE_IV   = CNT_W'(BASE_INTERVAL);

    logic [CNT_W-1:0] shortened;

    always_comb begin
        shortened = BASE_IV >> (rate - BASE_CODE);
        if (rate <= BASE_CODE) begin
            div_limit = DIV_W'(1) << (BASE_CODE - rate);
            interval  = BASE_IV;
        end else begin
            div_limit = '0;
            interval  = (shortened == '0) ? CNT_W'(1) : shortened;
        end
    end
endmodule

// File: rtl/rte_update_track.sv
module rte_update_track #(
    parameter int SEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             sample,
    input  logic [SEC_W-1:0] sec,
    output logic             hit
);
    localparam logic [SEC_W-1:0] INVALID = '1;

    logic [SEC_W-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= INVALID;
        end else if (arm) begin
            last_q <= INVALID;
        end else if (sample && (sec != last_q)) begin
            last_q <= sec;
        end
    end

    assign hit = sample && !arm && (sec != last_q) && (last_q != INVALID);
endmodule

// File: rtl/rte_alarm_match.sv
module rte_alarm_match #(
    parameter int FIELD_W = 8
) (
    input  logic               sample,
    input  logic [FIELD_W-1:0] hour,
    input  logic [FIELD_W-1:0] minute,
    input  logic [FIELD_W-1:0] second,
    input  logic [FIELD_W-1:0] al_hour,
    input  logic [FIELD_W-1:0] al_minute,
    input  logic [FIELD_W-1:0] al_second,
    output logic               hit
);
    assign hit = sample && (hour == al_hour) && (minute == al_minute)
                        && (second == al_second);
endmodule

// File: rtl/rtc_tick_emu.sv
module rtc_tick_emu
    import rtc_tick_emu_pkg::*;
#(
    parameter int CNT_W         = 32,
    parameter int FIELD_W       = 8,
    parameter int RATE_W        = 4,
    parameter int BASE_LOG2     = 6,
    parameter int BASE_INTERVAL = 1024
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [CNT_W-1:0]     counter,
    input  logic [FIELD_W-1:0]   cur_hour,
    input  logic [FIELD_W-1:0]   cur_min,
    input  logic [FIELD_W-1:0]   cur_sec,
    input  logic                 wr_en,
    input  logic [1:0]           wr_addr,
    input  logic [3*FIELD_W-1:0] wr_data,
    output logic                 tick_en,
    output logic [CNT_W-1:0]     cmp_target,
    output logic                 irq_strobe,
    output logic [15:0]          irq_word
);
    localparam int DIV_W = BASE_LOG2 + 2;

    rte_state_t               state_q, state_d;
    logic [NUM_SRC-1:0]       mask_q;
    logic [FIELD_W-1:0]       al_hour_q, al_min_q, al_sec_q;
    logic [RATE_W-1:0]        rate_q;
    logic [CNT_W-1:0]         target_q;
    logic                     tick_en_q;
    logic [DIV_W-1:0]         div_cnt_q;
    logic [NUM_SRC-1:0]       pend_q;
    logic [15:0]              word_q;

    logic [DIV_W-1:0]         div_limit;
    logic [CNT_W-1:0]         interval;
    logic [DIV_W-1:0]         div_nxt;
    logic                     mask_wr, rate_wr, alarm_wr;
    logic [NUM_SRC-1:0]       new_mask;
    logic                     restart, upd_arm, tick_go, ahead, chase_step;
    logic                     per_hit, alm_hit, upd_hit;

    rte_rate_decode #(
        .CNT_W(CNT_W), .RATE_W(RATE_W), .BASE_LOG2(BASE_LOG2),
        .BASE_INTERVAL(BASE_INTERVAL), .DIV_W(DIV_W)
    ) u_rate (
        .rate(rate_q), .div_limit(div_limit), .interval(interval)
    );

    rte_alarm_match #(.FIELD_W(FIELD_W)) u_alarm (
        .sample(tick_go && mask_q[SRC_ALM]),
        .hour(cur_hour), .minute(cur_min), .second(cur_sec),
        .al_hour(al_hour_q), .al_minute(al_min_q), .al_second(al_sec_q),
        .hit(alm_hit)
    );

    rte_update_track #(.SEC_W(FIELD_W)) u_update (
        .clk(clk), .rst_n(rst_n), .arm(upd_arm),
        .sample(tick_go && mask_q[SRC_UPD]), .sec(cur_sec), .hit(upd_hit)
    );

    // Write decode and tick qualification
    assign mask_wr    = wr_en && (wr_addr == REG_MASK);
    assign alarm_wr   = wr_en && (wr_addr == REG_ALARM);
    assign rate_wr    = wr_en && (wr_addr == REG_RATE);
    assign new_mask   = wr_data[NUM_SRC-1:0];
    assign restart    = mask_wr && (new_mask != '0) && (mask_q == '0);
    assign upd_arm    = mask_wr && new_mask[SRC_UPD] && !mask_q[SRC_UPD];
    assign tick_go    = tick && tick_en_q && (state_q == ST_IDLE);
    assign ahead      = $signed(target_q - counter) > 0;
    assign chase_step = (state_q == ST_CHASE) && !ahead;
    assign div_nxt    = div_cnt_q + DIV_W'(1);
    assign per_hit    = tick_go && mask_q[SRC_PER] && (div_nxt >= div_limit);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (tick_go) state_d = ST_CHASE;
            ST_CHASE: if (ahead)   state_d = (pend_q != '0) ? ST_EMIT : ST_IDLE;
            ST_EMIT:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Registers, comparator target and divider
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q    <= '0;
            al_hour_q <= '0;
            al_min_q  <= '0;
            al_sec_q  <= '0;
            rate_q    <= RATE_W'(BASE_LOG2);
            target_q  <= '0;
            tick_en_q <= 1'b0;
            div_cnt_q <= '0;
            pend_q    <= '0;
            word_q    <= '0;
        end else begin
            if (mask_wr) begin
                mask_q    <= new_mask;
                tick_en_q <= (new_mask != '0);
            end
            if (alarm_wr) begin
                al_hour_q <= wr_data[3*FIELD_W-1:2*FIELD_W];
                al_min_q  <= wr_data[2*FIELD_W-1:FIELD_W];
                al_sec_q  <= wr_data[FIELD_W-1:0];
            end
            if (rate_wr) rate_q <= wr_data[RATE_W-1:0];

            if (restart)
                target_q <= counter + interval;
            else if (tick_go || chase_step)
                target_q <= target_q + interval;

            if (!mask_q[SRC_PER] || rate_wr)
                div_cnt_q <= '0;
            else if (tick_go)
                div_cnt_q <= per_hit ? '0 : div_nxt;
            else if (chase_step && (div_cnt_q < div_limit))
                div_cnt_q <= div_nxt;

            if (tick_go) begin
                pend_q[SRC_PER] <= per_hit;
                pend_q[SRC_ALM] <= alm_hit;
                pend_q[SRC_UPD] <= upd_hit;
            end

            if ((state_q == ST_CHASE) && ahead && (pend_q != '0))
                word_q <= {WORD_TAG, 1'b1, 4'b0000, pend_q};
        end
    end

    // Outputs
    always_comb begin
        irq_strobe = (state_q == ST_EMIT);
        irq_word   = word_q;
        tick_en    = tick_en_q;
        cmp_target = target_q;
    end
endmodule

// File: rtl/rtc_tick_emu_chk.sv
module rtc_tick_emu_chk #(
    parameter int CNT_W   = 32,
    parameter int FIELD_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [1:0]           wr_addr,
    input logic [3*FIELD_W-1:0] wr_data,
    input logic [CNT_W-1:0]     counter,
    input logic                 tick_en,
    input logic [CNT_W-1:0]     cmp_target,
    input logic                 irq_strobe,
    input logic [15:0]          irq_word
);
    assert_restart_enables_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0 && wr_data[2:0] != 3'b000 && !tick_en) |=> tick_en);

    assert_zero_mask_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0 && wr_data[2:0] == 3'b000) |=> !tick_en);

    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_strobe |=> !irq_strobe);

    assert_word_format_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_strobe |-> (irq_word[15:8] == 8'h01 && irq_word[7] && irq_word[6:3] == 4'b0000
                        && irq_word[2:0] != 3'b000));

    assert_word_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_strobe |-> $stable(irq_word));

    assert_target_ahead_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_strobe |-> ($signed(cmp_target - counter) >= 0));
endmodule

bind rtc_tick_emu rtc_tick_emu_chk #(.CNT_W(CNT_W), .FIELD_W(FIELD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .counter(counter), .tick_en(tick_en), .cmp_target(cmp_target),
    .irq_strobe(irq_strobe), .irq_word(irq_word)
);

// File: tb/rtc_tick_emu_bench.sv
module rtc_tick_emu_bench;
    localparam int BIV = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [31:0] cnt = 32'd0;
    logic [7:0]  hr = 8'd0, mn = 8'd0, sc = 8'd0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [23:0] wr_data = 24'd0;
    logic        tick_en;
    logic [31:0] cmp_target;
    logic        irq_strobe;
    logic [15:0] irq_word;

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    rtc_tick_emu #(.BASE_LOG2(6), .BASE_INTERVAL(BIV)) u_rtc_tick_emu (
        .clk(clk), .rst_n(rst_n), .tick(tick), .counter(cnt),
        .cur_hour(hr), .cur_min(mn), .cur_sec(sc),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tick_en(tick_en), .cmp_target(cmp_target),
        .irq_strobe(irq_strobe), .irq_word(irq_word)
    );

    // Periodic vector table: rate code, ticks, expected flags, expected interval
    localparam int NV = 6;
    localparam int TV_RATE [NV] = '{6, 5, 4, 3, 7, 8};
    localparam int TV_TICK [NV] = '{4, 4, 8, 8, 3, 2};
    localparam int TV_FLAG [NV] = '{4, 2, 2, 1, 3, 2};
    localparam int TV_IV   [NV] = '{32, 32, 32, 32, 16, 8};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [23:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_tick(input logic [31:0] at, output int nstb, output logic [15:0] w);
        @(negedge clk);
        cnt = at; tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        nstb = 0; w = 16'h0;
        repeat (10) begin
            @(negedge clk);
            if (irq_strobe) begin
                nstb++;
                w = irq_word;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int n; logic [15:0] w; logic [31:0] t0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 tick_en", {31'd0, tick_en}, 32'd0);
        chk("R1 strobe", {31'd0, irq_strobe}, 32'd0);
        chk("R1 word", {16'd0, irq_word}, 32'd0);
        chk("R1 target", cmp_target, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 restart from all-zero mask
        cnt = 32'd1000;
        wr(2'd0, 24'h1);
        chk("R2 tick_en", {31'd0, tick_en}, 32'd1);
        chk("R2 target", cmp_target, 32'd1032);

        // R4/R5 periodic table
        for (int i = 0; i < NV; i++) begin
            int flags;
            wr(2'd0, 24'h0);
            wr(2'd2, 24'(TV_RATE[i]));
            cnt = 32'd5000;
            wr(2'd0, 24'h1);
            flags = 0;
            for (int k = 0; k < TV_TICK[i]; k++) begin
                do_tick(cmp_target, n, w);
                flags += n;
                if (n != 0) chk(TV_RATE[i] > 6 ? "R5 word" : "R4 word", {16'd0, w}, 32'h0181);
            end
            chk(TV_RATE[i] > 6 ? "R5 flags" : "R4 flags", flags, TV_FLAG[i]);
            chk(TV_RATE[i] > 6 ? "R5 target" : "R4 target", cmp_target,
                32'd5000 + 32'(TV_IV[i] * (TV_TICK[i] + 1)));
        end

        // R3 all-zero mask stops the channel
        wr(2'd0, 24'h0);
        chk("R3 tick_en", {31'd0, tick_en}, 32'd0);
        t0 = cmp_target;
        do_tick(t0, n, w);
        chk("R3 no strobe", n, 0);
        chk("R3 target held", cmp_target, t0);

        // R9/R10 lost ticks
        wr(2'd2, 24'd4);
        cnt = 32'd8000;
        wr(2'd0, 24'h1);
        chk("R9 start", cmp_target, 32'd8032);
        do_tick(32'd8128, n, w);
        chk("R10 no early flag", n, 0);
        chk("R9 chase target", cmp_target, 32'd8160);
        do_tick(cmp_target, n, w);
        chk("R10 lost ticks counted", n, 1);
        chk("R10 word", {16'd0, w}, 32'h0181);
        repeat (3) @(negedge clk);
        chk("R8 word held", {16'd0, irq_word}, 32'h0181);

        // R6 alarm
        wr(2'd0, 24'h0);
        wr(2'd1, 24'h0A141E);
        hr = 8'd10; mn = 8'd20; sc = 8'd30;
        cnt = 32'd9000;
        wr(2'd0, 24'h2);
        do_tick(cmp_target, n, w);
        chk("R6 alarm hit", {16'd0, w}, 32'h0182);
        chk("R8 one strobe", n, 1);
        sc = 8'd31;
        do_tick(cmp_target, n, w);
        chk("R6 alarm miss", n, 0);

        // R7 update with first-sample suppression
        sc = 8'd5;
        wr(2'd0, 24'h6);
        do_tick(cmp_target, n, w);
        chk("R7 first suppressed", n, 0);
        do_tick(cmp_target, n, w);
        chk("R7 same second", n, 0);
        sc = 8'd6;
        do_tick(cmp_target, n, w);
        chk("R7 update word", {16'd0, w}, 32'h0184);
        wr(2'd0, 24'h2);
        wr(2'd0, 24'h6);
        sc = 8'd7;
        do_tick(cmp_target, n, w);
        chk("R7 rearm suppressed", n, 0);
        sc = 8'd8;
        do_tick(cmp_target, n, w);
        chk("R7 update again", {16'd0, w}, 32'h0184);
        sc = 8'd30;
        do_tick(cmp_target, n, w);
        chk("R8 combined word", {16'd0, w}, 32'h0186);

        // R11 wraparound
        wr(2'd0, 24'h0);
        cnt = 32'hFFFF_FFC0;
        wr(2'd0, 24'h1);
        chk("R11 near top", cmp_target, 32'hFFFF_FFE0);
        do_tick(32'hFFFF_FFE0, n, w);
        chk("R11 wrapped target", cmp_target, 32'h0000_0000);
        chk("R11 no flag", n, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule